// File: doc/BRIEF.md
# Alternating-Triple Swap Encoder

This block prepares bytes for a serial link where every change of level on the wire costs switching energy. Each cycle it may accept one byte. It walks the byte from the top bit downward with a three-bit window. Whenever the window holds a strictly alternating triple (`010` or `101`), the two lower bits of that window are exchanged. The triple then has one internal edge instead of two. The walk then skips past the bits it has just rewritten.

Next to the recoded byte the block reports one side-band flag per nibble. A flag says that at least one exchange happened in that half of the byte, so a receiver knows where to look when it undoes the recoding. Code, flags and a valid bit are registered and appear one cycle after the input. Moving the byte onto the wire, decoding it and measuring power are done elsewhere.

Top module: `alt_swap_encoder`

## Requirements
- R1: A synchronous reset clears `out_valid`, `out_code` and `out_flags` to zero on the next clock edge, whatever the inputs are.
- R2: `out_valid` equals the `in_valid` value sampled at the previous clock edge. The latency is one cycle.
- R3: The window top starts at bit 7 and moves down. At top index i, if bits i, i-1 and i-2 of the working byte read `010` they become `001`, and if they read `101` they become `110`.
- R4: After an exchange at window top i, the next window top is i-2, taken on the rewritten byte. With no exchange it is i-1. The lowest window top is 2. For example 0x55 encodes to 0x39 and 0xAA encodes to 0xC6.
- R5: A byte whose scan finds no alternating triple (for example 0x00, 0xFF, 0x33) is output unchanged, with both flags 0.
- R6: `out_flags[1]` (upper nibble) is 1 exactly when some exchange had its higher exchanged bit at index 7..4. For example 0x20 gives 0x10 with flags 2'b10, and 0x10 gives 0x08 with flags 2'b10.
- R7: `out_flags[0]` (lower nibble) is 1 exactly when some exchange had its higher exchanged bit at index 3..1. For example 0x08 gives 0x04 with flags 2'b01, and 0x02 gives 0x01 with flags 2'b01.
- R8: The number of adjacent-bit level changes inside an encoded byte never exceeds that number in the input byte.
- R9: While `in_valid` is low, `out_code` and `out_flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_byte` as a byte to encode this cycle |
| in_byte | input | WIDTH (8) | Raw data byte, bit 7 scanned first |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_code | output | WIDTH (8) | Registered encoded byte |
| out_flags | output | WIDTH/GROUP (2) | Per-nibble exchange flags, bit 1 upper nibble, bit 0 lower nibble |

## Verification
The hardest cases to reach are chained exchanges. In these a later window reads a bit that an earlier exchange has rewritten, and a skipped window top must not be examined. Bytes like 0x55 and 0xAA reach them only when the whole skip order is right. Walking every one of the 256 byte values against an independent scan model covers every chain and every point where a flag boundary falls, including exchanges whose two bits straddle the nibble boundary. Idle cycles between the bytes, and a reset taken while a byte is valid, check the hold and clear behaviour.

// File: rtl/ase_pkg.sv
package ase_pkg;

    localparam int unsigned ASE_MAX_W = 64;

    // number of adjacent-bit level changes within the low w bits of v
    function automatic int unsigned ase_edges(input logic [ASE_MAX_W-1:0] v,
                                              input int unsigned w);
        int unsigned n;
        n = 0;
        for (int unsigned b = 1; b < ASE_MAX_W; b++) begin
            if (b < w && v[b] != v[b-1]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/ase_window.sv
// One window position of the scan: top bit TOP, then TOP-1 and TOP-2.
module ase_window #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned TOP   = 7
) (
    input  logic [WIDTH-1:0] byte_i,
    input  logic             blocked_i,
    output logic [WIDTH-1:0] byte_o,
    output logic             swap_o
);
    localparam int unsigned MID = TOP - 1;
    localparam int unsigned LOW = TOP - 2;

    logic alt_d;

    always_comb begin
        alt_d  = (byte_i[TOP] != byte_i[MID]) && (byte_i[MID] != byte_i[LOW]);
        swap_o = alt_d && !blocked_i;
        byte_o = byte_i;
        if (swap_o) begin
            byte_o[MID] = byte_i[LOW];
            byte_o[LOW] = byte_i[MID];
        end
    end

endmodule

// File: rtl/ase_scan.sv
// Chain of windows from the top down, plus per-group flag attribution.
module ase_scan #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned GROUP = 4
) (
    input  logic [WIDTH-1:0]       raw_i,
    output logic [WIDTH-1:0]       code_o,
    output logic [WIDTH/GROUP-1:0] flags_o
);
    localparam int unsigned NGRP = WIDTH / GROUP;

    logic [WIDTH-1:0] stage_b [1:WIDTH];
    logic [WIDTH:2]   swap_v;

    assign stage_b[WIDTH] = raw_i;
    assign swap_v[WIDTH]  = 1'b0;

    for (genvar k = WIDTH - 1; k >= 2; k--) begin : g_win
        // a window whose top was consumed by the exchange one above is skipped
        ase_window #(.WIDTH(WIDTH), .TOP(k)) i_win (
            .byte_i   (stage_b[k+1]),
            .blocked_i(swap_v[k+1]),
            .byte_o   (stage_b[k]),
            .swap_o   (swap_v[k])
        );
    end

    assign stage_b[1] = stage_b[2];
    assign code_o     = stage_b[1];

    always_comb begin
        flags_o = '0;
        for (int unsigned k = 2; k < WIDTH; k++) begin
            // attribution by the higher exchanged bit, index k-1
            if (swap_v[k]) flags_o[(k-1)/GROUP] = 1'b1;
        end
    end

    // R5: no exchange anywhere means the byte is untouched
    always_comb begin
        if (!$isunknown(raw_i) && swap_v[WIDTH-1:2] == '0)
            p_pass_through_r5: assert (code_o == raw_i);
    end

    logic [NGRP-1:0] unused_ok;
    assign unused_ok = '0;

endmodule

// File: rtl/alt_swap_encoder.sv
module alt_swap_encoder #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned GROUP = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [WIDTH-1:0]       in_byte,
    output logic                   out_valid,
    output logic [WIDTH-1:0]       out_code,
    output logic [WIDTH/GROUP-1:0] out_flags
);
    import ase_pkg::*;

    localparam int unsigned NGRP = WIDTH / GROUP;

    typedef struct packed {
        logic            valid;
        logic [WIDTH-1:0] code;
        logic [NGRP-1:0]  flags;
    } out_t;

    out_t             st_d, st_q;
    logic [WIDTH-1:0] code_c;
    logic [NGRP-1:0]  flags_c;

    ase_scan #(.WIDTH(WIDTH), .GROUP(GROUP)) i_scan (
        .raw_i  (in_byte),
        .code_o (code_c),
        .flags_o(flags_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.code  = code_c;
            st_d.flags = flags_c;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_code  = st_q.code;
    assign out_flags = st_q.flags;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_code == '0 && out_flags == '0));

    // R2
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_code) && $stable(out_flags)));

    // R8
    p_edges_no_worse_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (ase_edges(ASE_MAX_W'(out_code), WIDTH)
                      <= ase_edges(ASE_MAX_W'($past(in_byte)), WIDTH)));

    // R5, R6, R7: flags clear exactly when the byte is unchanged
    p_flags_vs_change_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_flags == '0) == (out_code == $past(in_byte))));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp_chk
        // R6 / R7: a raised group flag means that group's bits changed
        p_flag_group_r7: assert property (@(posedge clk) disable iff (rst)
            (in_valid ##1 out_flags[g]) |->
                (out_code[g*GROUP +: GROUP] != $past(in_byte[g*GROUP +: GROUP])));
    end

endmodule

// File: tb/test_alt_swap_encoder.sv
module test_alt_swap_encoder;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       out_valid;
    logic [7:0] out_code;
    logic [1:0] out_flags;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;

    logic       exp_valid;
    logic [7:0] exp_code;
    logic [1:0] exp_flags;

    always #2 clk = ~clk;

    alt_swap_encoder i_alt_swap_encoder (
        .clk, .rst, .in_valid, .in_byte, .out_valid, .out_code, .out_flags
    );

    // behavioural reference of the scan
    function automatic logic [9:0] model(input logic [7:0] b);
        logic [7:0] w;
        logic [1:0] f;
        logic       t;
        int i;
        w = b;
        f = 2'b00;
        i = 7;
        while (i >= 2) begin
            if (w[i] != w[i-1] && w[i-1] != w[i-2]) begin
                t = w[i-1];
                w[i-1] = w[i-2];
                w[i-2] = t;
                if (i - 1 >= 4) f[1] = 1'b1; else f[0] = 1'b1;
                i = i - 2;
            end else begin
                i = i - 1;
            end
        end
        return {f, w};
    endfunction

    function automatic int edges(input logic [7:0] v);
        int n;
        n = 0;
        for (int b = 1; b < 8; b++) if (v[b] != v[b-1]) n++;
        return n;
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive, let the edge pass, update model, compare
    task automatic step(input logic r, input logic v, input logic [7:0] b, input string req);
        logic [9:0] m;
        @(negedge clk);
        rst = r; in_valid = v; in_byte = b;
        @(posedge clk);
        #1;
        m = model(b);
        if (r) begin
            exp_valid = 1'b0; exp_code = '0; exp_flags = '0;
        end else begin
            exp_valid = v;
            if (v) begin exp_code = m[7:0]; exp_flags = m[9:8]; end
        end
        check({req, " valid"}, out_valid, exp_valid);
        check({req, " code"},  out_code,  exp_code);
        check({req, " flags"}, out_flags, exp_flags);
        if (!r && v) check("R8 edges", (edges(out_code) <= edges(b)), 1);
    endtask

    task automatic fixed(input logic [7:0] b, input logic [7:0] c, input logic [1:0] f,
                         input string req);
        step(1'b0, 1'b1, b, req);
        check({req, " fixed code"},  out_code,  c);
        check({req, " fixed flags"}, out_flags, f);
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_byte = 8'h55;
        exp_valid = 1'b0; exp_code = '0; exp_flags = '0;
        step(1'b1, 1'b1, 8'h55, "R1 reset");
        step(1'b1, 1'b1, 8'hAA, "R1 reset");

        // hand-worked values
        fixed(8'h55, 8'h39, 2'b11, "R4");
        fixed(8'hAA, 8'hC6, 2'b11, "R4");
        fixed(8'h00, 8'h00, 2'b00, "R5");
        fixed(8'hFF, 8'hFF, 2'b00, "R5");
        fixed(8'h33, 8'h33, 2'b00, "R5");
        fixed(8'h20, 8'h10, 2'b10, "R6");
        fixed(8'h10, 8'h08, 2'b10, "R6");
        fixed(8'h08, 8'h04, 2'b01, "R7");
        fixed(8'h02, 8'h01, 2'b01, "R7");
        fixed(8'h40, 8'h20, 2'b10, "R3");
        fixed(8'hBF, 8'hDF, 2'b10, "R3");

        // R2 / R9: idle cycles hold code and flags
        step(1'b0, 1'b0, 8'h55, "R9 idle");
        step(1'b0, 1'b0, 8'h02, "R9 idle");

        // exhaustive sweep, with an idle gap every fifth byte
        for (int b = 0; b < 256; b++) begin
            step(1'b0, 1'b1, 8'(b), "R3 sweep");
            if (b % 5 == 4) step(1'b0, 1'b0, 8'(b ^ 8'hA5), "R9 gap");
        end

        // R1: reset mid-stream with valid input
        step(1'b1, 1'b1, 8'h55, "R1 midreset");
        step(1'b0, 1'b0, 8'h00, "R2 after reset");
        step(1'b0, 1'b1, 8'hAA, "R2 resume");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule